// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control that sits around a successive-approximation converter. It holds the converter off until the power enable is raised. It then waits a programmable settling period. After that it runs timed conversions. A conversion starts from a one-cycle software start pulse or from the rising edge of an external trigger. Each conversion lasts a fixed number of clock cycles. At the end the 12-bit sample on `sampleIn` is taken as valid, aligned into a 16-bit result register, and flagged.

With the repeat bit set, the sequencer begins the next conversion in the same cycle the previous result lands, and needs no further request. Clearing the bit lets the conversion in flight complete and then parks the block. With the auto-injection bit set, every regular conversion is followed by one injected conversion of equal length. Its result goes to a separate register with its own flag. The done flags are sticky until software pulses the matching clear input. An interrupt line follows the regular done flag when enabled.

Top module: `adc_seq`

## Requirements
- R1: After reset both result registers read 0, both done flags and `irq` are 0, and `busy` is 0.
- R2: A `swStart` pulse sampled at clock edge E while the block is idle sets `eocFlag` and loads `dataReg` at edge E+15, and not before.
- R3: A rising edge on `extTrig` starts a conversion exactly as `swStart` does. Holding `extTrig` high afterwards starts no further conversion.
- R4: With `alignLeft`=0 the sample sits in `dataReg[11:0]` and bits 15:12 are 0. With `alignLeft`=1 it sits in bits 15:4 and bits 3:0 are 0. The value of `alignLeft` at the capture edge decides.
- R5: `eocFlag` stays 1 until an `eocClear` pulse. A set and a clear at the same edge leave it at 1.
- R6: `irq` is 1 exactly when `eocFlag` is 1 and `eocIrqEn` is 1.
- R7: With `contMode`=1, after a single start request a new result lands every 15 cycles with no further request.
- R8: When `contMode` is cleared during a repeat run, the conversion in flight completes, after which `busy` drops and no more results appear.
- R9: After `powerOn` is seen high at edge P, the first conversion starts no earlier than edge P+`stabCount`. A start request made during that wait is held and launched at that edge.
- R10: While `powerOn` is 0, start requests are ignored and `busy` is 0.
- R11: With `autoInj`=1, each regular result is followed 15 cycles later by an injected result in `injDataReg` with `injEocFlag` set. `dataReg` is unchanged by it, and `injEocFlag` stays set until `injClear`.
- R12: Start requests that arrive while a conversion is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerOn | input | 1 | Converter enable; low aborts and holds off |
| stabCount | input | 8 | Settling wait in cycles after power-up |
| swStart | input | 1 | Software start pulse |
| extTrig | input | 1 | External trigger, rising edge starts |
| contMode | input | 1 | Repeat conversions back to back |
| autoInj | input | 1 | Follow each regular conversion with an injected one |
| alignLeft | input | 1 | 1: left-align result, 0: right-align |
| eocIrqEn | input | 1 | Interrupt enable for regular done flag |
| eocClear | input | 1 | Clears regular done flag |
| injClear | input | 1 | Clears injected done flag |
| sampleIn | input | 12 | Regular converter sample, valid at end of count |
| injSampleIn | input | 12 | Injected converter sample, valid at end of count |
| dataReg | output | 16 | Aligned regular result |
| injDataReg | output | 16 | Aligned injected result |
| eocFlag | output | 1 | Regular done flag |
| injEocFlag | output | 1 | Injected done flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Conversion in progress |

## Verification
A request seen at edge E produces its regular result at edge E+15. The injected follow-up lands at E+30, and under repeat mode each further result lands 15 edges after the one before. After power-up the first result is due at P+`stabCount`+15. The bench counts clock edges and files every expected result with the exact edge at which it is due. It samples on the falling edge after that edge, and a flag check one cycle earlier catches any early result. Each conversion uses a distinct sample value, so a result that arrives late or is captured twice shows up as a data mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_STAB,
    ST_IDLE,
    ST_CONV,
    ST_INJ
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReg;
    logic capInj;
  } dpStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 15,
  parameter int STAB_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerOn,
  input  logic [STAB_W-1:0] stabCount,
  input  logic              swStart,
  input  logic              extTrig,
  input  logic              contMode,
  input  logic              autoInj,
  output dpStrobe_t         strobe,
  output logic              busy
);

  localparam int CNT_W = $clog2(CONV_CYCLES);

  seqState_t         state;
  logic [CNT_W-1:0]  convCnt;
  logic [STAB_W-1:0] stabCnt;
  logic              pending;
  logic              trigPrev;
  logic              startReq;
  logic              convLast;
  logic              stabDone;

  assign startReq = swStart | (extTrig & ~trigPrev);
  assign convLast = (convCnt == CNT_W'(CONV_CYCLES - 1));
  assign stabDone = ({1'b0, stabCnt} + {{STAB_W{1'b0}}, 1'b1}) >= {1'b0, stabCount};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_OFF;
      convCnt  <= '0;
      stabCnt  <= '0;
      pending  <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= extTrig;
      if (!powerOn) begin
        state   <= ST_OFF;
        pending <= 1'b0;
      end else begin
        unique case (state)
          ST_OFF: begin
            state   <= ST_STAB;
            stabCnt <= '0;
            pending <= 1'b0;
          end
          ST_STAB: begin
            if (stabDone) begin
              pending <= 1'b0;
              convCnt <= '0;
              state   <= (pending | startReq) ? ST_CONV : ST_IDLE;
            end else begin
              pending <= pending | startReq;
              stabCnt <= stabCnt + STAB_W'(1);
            end
          end
          ST_IDLE: begin
            if (startReq) begin
              state   <= ST_CONV;
              convCnt <= '0;
            end
          end
          ST_CONV: begin
            if (convLast) begin
              convCnt <= '0;
              if (autoInj)       state <= ST_INJ;
              else if (contMode) state <= ST_CONV;
              else               state <= ST_IDLE;
            end else begin
              convCnt <= convCnt + CNT_W'(1);
            end
          end
          ST_INJ: begin
            if (convLast) begin
              convCnt <= '0;
              state   <= contMode ? ST_CONV : ST_IDLE;
            end else begin
              convCnt <= convCnt + CNT_W'(1);
            end
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  always_comb begin
    strobe.capReg = powerOn && (state == ST_CONV) && convLast;
    strobe.capInj = powerOn && (state == ST_INJ) && convLast;
  end

  assign busy = (state == ST_CONV) || (state == ST_INJ);

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                alignLeft,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] injSampleIn,
  input  logic                eocClear,
  input  logic                injClear,
  input  logic                eocIrqEn,
  output logic [DATA_W-1:0]   dataReg,
  output logic [DATA_W-1:0]   injDataReg,
  output logic                eocFlag,
  output logic                injEocFlag,
  output logic                irq
);

  localparam int PAD_W = DATA_W - SAMPLE_W;

  logic [DATA_W-1:0] regAligned;
  logic [DATA_W-1:0] injAligned;

  always_comb begin
    if (alignLeft) begin
      regAligned = {sampleIn, {PAD_W{1'b0}}};
      injAligned = {injSampleIn, {PAD_W{1'b0}}};
    end else begin
      regAligned = {{PAD_W{1'b0}}, sampleIn};
      injAligned = {{PAD_W{1'b0}}, injSampleIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg    <= '0;
      injDataReg <= '0;
      eocFlag    <= 1'b0;
      injEocFlag <= 1'b0;
    end else begin
      if (strobe.capReg)  dataReg    <= regAligned;
      if (strobe.capInj)  injDataReg <= injAligned;
      // a new result wins over a clear in the same cycle
      if (strobe.capReg)  eocFlag    <= 1'b1;
      else if (eocClear)  eocFlag    <= 1'b0;
      if (strobe.capInj)  injEocFlag <= 1'b1;
      else if (injClear)  injEocFlag <= 1'b0;
    end
  end

  assign irq = eocFlag & eocIrqEn;

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 15,
  parameter int STAB_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                powerOn,
  input  logic [STAB_W-1:0]   stabCount,
  input  logic                swStart,
  input  logic                extTrig,
  input  logic                contMode,
  input  logic                autoInj,
  input  logic                alignLeft,
  input  logic                eocIrqEn,
  input  logic                eocClear,
  input  logic                injClear,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] injSampleIn,
  output logic [DATA_W-1:0]   dataReg,
  output logic [DATA_W-1:0]   injDataReg,
  output logic                eocFlag,
  output logic                injEocFlag,
  output logic                irq,
  output logic                busy
);

  dpStrobe_t strobe;

  adc_seq_ctrl #(
    .CONV_CYCLES(CONV_CYCLES),
    .STAB_W     (STAB_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .powerOn  (powerOn),
    .stabCount(stabCount),
    .swStart  (swStart),
    .extTrig  (extTrig),
    .contMode (contMode),
    .autoInj  (autoInj),
    .strobe   (strobe),
    .busy     (busy)
  );

  adc_seq_dp #(
    .SAMPLE_W(SAMPLE_W),
    .DATA_W  (DATA_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .alignLeft  (alignLeft),
    .sampleIn   (sampleIn),
    .injSampleIn(injSampleIn),
    .eocClear   (eocClear),
    .injClear   (injClear),
    .eocIrqEn   (eocIrqEn),
    .dataReg    (dataReg),
    .injDataReg (injDataReg),
    .eocFlag    (eocFlag),
    .injEocFlag (injEocFlag),
    .irq        (irq)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerOn,
  input logic              eocClear,
  input logic              injClear,
  input logic              eocFlag,
  input logic              injEocFlag,
  input logic              irq,
  input logic              busy,
  input logic [DATA_W-1:0] dataReg,
  input logic [DATA_W-1:0] injDataReg
);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    eocFlag && !eocClear |=> eocFlag);

  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> eocFlag);

  a_r10_off_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |=> !busy);

  a_r2_data_only_from_conv: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(dataReg));

  a_r11_inj_only_from_conv: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(injDataReg));

  a_r11_inj_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    injEocFlag && !injClear |=> injEocFlag);

endmodule

bind adc_seq adc_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .powerOn   (powerOn),
  .eocClear  (eocClear),
  .injClear  (injClear),
  .eocFlag   (eocFlag),
  .injEocFlag(injEocFlag),
  .irq       (irq),
  .busy      (busy),
  .dataReg   (dataReg),
  .injDataReg(injDataReg)
);

// File: tb/test_adc_seq.sv
module test_adc_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        powerOn = 1'b0;
  logic [7:0]  stabCount = 8'd3;
  logic        swStart = 1'b0;
  logic        extTrig = 1'b0;
  logic        contMode = 1'b0;
  logic        autoInj = 1'b0;
  logic        alignLeft = 1'b0;
  logic        eocIrqEn = 1'b0;
  logic        eocClear = 1'b0;
  logic        injClear = 1'b0;
  logic [11:0] sampleIn = '0;
  logic [11:0] injSampleIn = '0;
  logic [15:0] dataReg;
  logic [15:0] injDataReg;
  logic        eocFlag;
  logic        injEocFlag;
  logic        irq;
  logic        busy;

  adc_seq i_adc_seq (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .stabCount(stabCount),
    .swStart(swStart), .extTrig(extTrig), .contMode(contMode),
    .autoInj(autoInj), .alignLeft(alignLeft), .eocIrqEn(eocIrqEn),
    .eocClear(eocClear), .injClear(injClear), .sampleIn(sampleIn),
    .injSampleIn(injSampleIn), .dataReg(dataReg), .injDataReg(injDataReg),
    .eocFlag(eocFlag), .injEocFlag(injEocFlag), .irq(irq), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    bit          isInj;
    logic [15:0] val;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] aligned(input logic [11:0] s, input bit left);
    return left ? {s, 4'b0000} : {4'b0000, s};
  endfunction

  // request sampled at next edge; result due 15 edges later (+extra)
  task automatic swReq(input logic [11:0] s, input bit left, input int extra,
                       input string req);
    sampleIn  = s;
    alignLeft = left;
    swStart   = 1'b1;
    q.push_back('{cyc + 16 + extra, 1'b0, aligned(s, left), req});
    @(negedge clk);
    swStart = 1'b0;
  endtask

  task automatic clrEoc();
    eocClear = 1'b1;
    @(negedge clk);
    eocClear = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && q[0].due < cyc) begin
        item_t missed;
        missed = q.pop_front();
        check(missed.req, "result missed", 32'(cyc), 32'(missed.due));
      end
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.isInj) begin
          check(it.req, "injDataReg", 32'(injDataReg), 32'(it.val));
          check(it.req, "injEocFlag", 32'(injEocFlag), 32'd1);
        end else begin
          check(it.req, "dataReg", 32'(dataReg), 32'(it.val));
          check(it.req, "eocFlag", 32'(eocFlag), 32'd1);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    check("R1", "dataReg", 32'(dataReg), 0);
    check("R1", "injDataReg", 32'(injDataReg), 0);
    check("R1", "eocFlag", 32'(eocFlag), 0);
    check("R1", "irq", 32'(irq), 0);
    check("R1", "busy", 32'(busy), 0);

    // R10 requests ignored while powered off
    sampleIn = 12'h7E7;
    swStart = 1'b1; waitN(1); swStart = 1'b0;
    extTrig = 1'b1; waitN(1); extTrig = 1'b0;
    waitN(25);
    check("R10", "eocFlag", 32'(eocFlag), 0);
    check("R10", "busy", 32'(busy), 0);
    check("R10", "dataReg", 32'(dataReg), 0);

    // R9 power-up wait, request during wait held pending
    powerOn = 1'b1;
    waitN(1);
    c0 = cyc;
    swReq(12'h5C1, 1'b0, 2, "R9");
    waitN(16);
    check("R9", "eocFlag early", 32'(eocFlag), 0);
    check("R9", "busy during conv", 32'(busy), 1);
    waitN(2);
    // R5 flag remains set without clear
    waitN(8);
    check("R5", "eocFlag sticky", 32'(eocFlag), 1);
    clrEoc();
    check("R5", "eocFlag cleared", 32'(eocFlag), 0);

    // R2 / R4 right alignment
    swReq(12'hABC, 1'b0, 0, "R2 R4 right");
    waitN(14);
    check("R2", "eocFlag before due", 32'(eocFlag), 0);
    waitN(4);
    clrEoc();
    // R4 left alignment
    swReq(12'h5A3, 1'b1, 0, "R4 left");
    waitN(18);

    // R6 interrupt follows flag and enable
    eocIrqEn = 1'b1;
    waitN(1);
    check("R6", "irq enabled", 32'(irq), 1);
    eocIrqEn = 1'b0;
    waitN(1);
    check("R6", "irq disabled", 32'(irq), 0);
    eocIrqEn = 1'b1;
    clrEoc();
    check("R6", "irq after clear", 32'(irq), 0);
    eocIrqEn = 1'b0;

    // R5 set wins over clear in the same edge
    swReq(12'h111, 1'b0, 0, "R5 set-vs-clear");
    waitN(14);
    eocClear = 1'b1;
    waitN(1);
    eocClear = 1'b0;
    check("R5", "set beats clear", 32'(eocFlag), 1);
    clrEoc();

    // R3 external trigger rising edge, level does not retrigger
    sampleIn = 12'h2C7;
    alignLeft = 1'b0;
    extTrig = 1'b1;
    q.push_back('{cyc + 16, 1'b0, 16'h02C7, "R3"});
    waitN(20);
    clrEoc();
    waitN(30);
    check("R3", "no retrigger flag", 32'(eocFlag), 0);
    check("R3", "no retrigger busy", 32'(busy), 0);
    extTrig = 1'b0;
    waitN(2);

    // R12 request mid-conversion ignored
    swReq(12'h3D1, 1'b0, 0, "R12");
    waitN(5);
    swStart = 1'b1; waitN(1); swStart = 1'b0;
    waitN(10);
    clrEoc();
    check("R12", "busy after result", 32'(busy), 0);
    waitN(25);
    check("R12", "no extra result", 32'(eocFlag), 0);

    // R7 continuous mode, R8 stop after current
    contMode = 1'b1;
    c0 = cyc;
    swReq(12'h101, 1'b0, 0, "R7 first");
    q.push_back('{c0 + 31, 1'b0, 16'h0202, "R7 second"});
    q.push_back('{c0 + 46, 1'b0, 16'h0303, "R8 in-flight"});
    waitN(15);
    sampleIn = 12'h202;
    waitN(15);
    sampleIn = 12'h303;
    waitN(4);
    contMode = 1'b0;
    waitN(11);
    waitN(1);
    check("R8", "busy after last", 32'(busy), 0);
    clrEoc();
    waitN(30);
    check("R8", "no more results", 32'(eocFlag), 0);

    // R11 automatic injected conversion
    autoInj = 1'b1;
    injSampleIn = 12'h456;
    c0 = cyc;
    swReq(12'h123, 1'b0, 0, "R11 regular");
    q.push_back('{c0 + 31, 1'b1, 16'h0456, "R11 injected"});
    waitN(40);
    check("R11", "dataReg kept", 32'(dataReg), 32'h0123);
    check("R11", "injEocFlag sticky", 32'(injEocFlag), 1);
    injClear = 1'b1; waitN(1); injClear = 1'b0;
    check("R11", "injEocFlag cleared", 32'(injEocFlag), 0);
    autoInj = 1'b0;

    waitN(5);
    check("R2", "scoreboard drained", 32'(q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule